// File: doc/BRIEF.md
# Selectable-Latency Read Output Stage

This block sits between a memory array and one port's data bus and decides when, and on which byte lanes, read data reaches the bus. A static latency input chooses between two modes. In direct mode, the word the array returns for the address registered at a clock edge goes straight to the output. In registered mode, that word passes through one output register and appears one cycle later. The block registers the two chip enables, the read/write control and the per-lane byte selects. It combines them with an asynchronous active-low output enable to give one drive flag per lane. The pad logic uses these flags to control the tri-state drivers.

The block buffers its enables differently in each mode. In registered mode the chip enables and the read/write control pass through two stages, so selecting, deselecting and write turnaround take two edges to reach the drive flags. The byte selects always pass through one stage. The output enable bypasses the clock entirely. In registered mode the output register loads only for a registered read, so the bus keeps its last word while no new read occurs. A change on the latency input is adopted only after both enable stages have been idle for a full cycle.

Top module: `rd_latency_stage`

## Requirements
- R1: While reset is asserted, and afterwards until a read has been registered, every drive flag is low.
- R2: With the latency input low, a read registered at edge k (chip enables asserted, `rw_n` high) drives the flags and presents the array word for that address in the cycle after edge k.
- R3: With the latency input high, the word read at edge k appears on `dout` after edge k+1. It comes from the output register, and the drive flags rise after edge k+1.
- R4: The chip enables (active when `ce_lo_n` is low and `ce_hi` is high) take one edge to reach the drive flags in direct mode and two edges in registered mode.
- R5: Byte selects are active low. Bit 0 controls the lower lane (`dout[8:0]`) and bit 1 controls the upper lane (`dout[17:9]`). In both modes each select reaches its flag after one edge.
- R6: While `oe_n` is high, every drive flag is low at once, with no clock edge needed. When `oe_n` returns low, the flags are restored without a clock edge.
- R7: A write (`rw_n` low) turns the flags low: after the same edge in direct mode, and after the following edge in registered mode.
- R8: In registered mode `dout` changes only at an edge whose output-register load was set up by a read registered one edge earlier. Otherwise it holds its word, even while the array word changes.
- R9: A new value on the latency input takes effect only at an edge where both enable stages hold a deselect. Before that edge the previous latency stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_mode | input | 1 | Latency request: 0 direct, 1 registered (static) |
| ce_lo_n | input | 1 | Active-low chip enable |
| ce_hi | input | 1 | Active-high chip enable |
| rw_n | input | 1 | 1 read, 0 write |
| byte_sel_n | input | LANES | Active-low byte-lane selects, bit 0 lower lane |
| oe_n | input | 1 | Asynchronous active-low output enable |
| arr_rdata | input | LANES*LANE_W | Array word for the address registered at the last edge |
| dout | output | LANES*LANE_W | Read data toward the bus |
| lane_drive | output | LANES | Per-lane drive flag for the tri-state pads |

## Verification
On every cycle the assertions check the following:
- a raised flag in direct mode is backed by a select and a read one edge earlier, and in registered mode by the same two edges earlier;
- each lane flag implies its byte select was active one edge earlier;
- a high output enable forces every flag low;
- a change of `dout` in registered mode is traced to a read two edges back;
- a change of latency is preceded by two deselected edges.

Only the bench's scenarios can show the exact data values and the cycle in which each word appears. They also show the immediate recovery when the output enable falls, the word held while the array output changes, and that a latency request is ignored while the port stays selected.

// File: rtl/rdlat_pkg.sv
package rdlat_pkg;

  typedef enum logic {
    LAT_DIRECT = 1'b0,
    LAT_REG    = 1'b1
  } lat_mode_e;

  // Port is selected when the low enable is low and the high enable is high.
  function automatic logic sel_live(input logic ce_lo_n, input logic ce_hi);
    return (!ce_lo_n) && ce_hi;
  endfunction

  // Read qualifier for one enable stage.
  function automatic logic read_live(input logic sel, input logic rd);
    return sel && rd;
  endfunction

endpackage

// File: rtl/rdlat_enable_path.sv
module rdlat_enable_path
  import rdlat_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lat_mode_e        mode_eff,
  input  logic             ce_lo_n,
  input  logic             ce_hi,
  input  logic             rw_n,
  input  logic [LANES-1:0] byte_sel_n,
  output logic             read_on,
  output logic [LANES-1:0] lane_on,
  output logic             capture,
  output logic             stages_idle
);

  logic             sel_s1, rd_s1;
  logic             sel_s2, rd_s2;
  logic [LANES-1:0] lane_s1;

  // First stage: chip enables, read/write control and byte selects.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_s1  <= 1'b0;
      rd_s1   <= 1'b0;
      lane_s1 <= '0;
    end else begin
      sel_s1  <= sel_live(ce_lo_n, ce_hi);
      rd_s1   <= rw_n;
      lane_s1 <= ~byte_sel_n;
    end
  end

  // Second stage: chip enables and read/write control only.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_s2 <= 1'b0;
      rd_s2  <= 1'b0;
    end else begin
      sel_s2 <= sel_s1;
      rd_s2  <= rd_s1;
    end
  end

  always_comb begin
    if (mode_eff == LAT_REG) read_on = read_live(sel_s2, rd_s2);
    else                     read_on = read_live(sel_s1, rd_s1);
  end

  assign lane_on     = lane_s1;
  assign capture     = read_live(sel_s1, rd_s1);
  assign stages_idle = !sel_s1 && !sel_s2;

endmodule

// File: rtl/rdlat_mode_ctl.sv
module rdlat_mode_ctl
  import rdlat_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      mode_req,
  input  logic      stages_idle,
  output lat_mode_e mode_eff
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           mode_eff <= LAT_DIRECT;
    else if (stages_idle) mode_eff <= lat_mode_e'(mode_req);
  end

endmodule

// File: rtl/rdlat_data_path.sv
module rdlat_data_path
  import rdlat_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lat_mode_e        mode_eff,
  input  logic             capture,
  input  logic [WIDTH-1:0] arr_rdata,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] out_q;

  // The output register loads only for a registered read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       out_q <= '0;
    else if (capture) out_q <= arr_rdata;
  end

  assign dout = (mode_eff == LAT_REG) ? out_q : arr_rdata;

endmodule

// File: rtl/rdlat_lane_drive.sv
module rdlat_lane_drive #(
  parameter int LANES = 2
) (
  input  logic             read_on,
  input  logic [LANES-1:0] lane_on,
  input  logic             oe_n,
  output logic [LANES-1:0] lane_drive
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_drive[g] = read_on && lane_on[g] && !oe_n;
  end

endmodule

// File: rtl/rd_latency_stage.sv
module rd_latency_stage
  import rdlat_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pipe_mode,
  input  logic                    ce_lo_n,
  input  logic                    ce_hi,
  input  logic                    rw_n,
  input  logic [LANES-1:0]        byte_sel_n,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] arr_rdata,
  output logic [LANES*LANE_W-1:0] dout,
  output logic [LANES-1:0]        lane_drive
);

  localparam int WIDTH = LANES * LANE_W;

  lat_mode_e        mode_eff;
  logic             read_on;
  logic [LANES-1:0] lane_on;
  logic             capture;
  logic             stages_idle;

  rdlat_mode_ctl u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_req    (pipe_mode),
    .stages_idle (stages_idle),
    .mode_eff    (mode_eff)
  );

  rdlat_enable_path #(.LANES(LANES)) u_en (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_eff    (mode_eff),
    .ce_lo_n     (ce_lo_n),
    .ce_hi       (ce_hi),
    .rw_n        (rw_n),
    .byte_sel_n  (byte_sel_n),
    .read_on     (read_on),
    .lane_on     (lane_on),
    .capture     (capture),
    .stages_idle (stages_idle)
  );

  rdlat_data_path #(.WIDTH(WIDTH)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_eff  (mode_eff),
    .capture   (capture),
    .arr_rdata (arr_rdata),
    .dout      (dout)
  );

  rdlat_lane_drive #(.LANES(LANES)) u_drive (
    .read_on    (read_on),
    .lane_on    (lane_on),
    .oe_n       (oe_n),
    .lane_drive (lane_drive)
  );

  // Cycles since reset, saturating; used only to gate history-based checks.
  logic [1:0] live_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                live_cnt <= '0;
    else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
  end

  wire port_read = sel_live(ce_lo_n, ce_hi) && rw_n;

  a_r2_direct_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_eff == LAT_DIRECT && |lane_drive) |-> $past(port_read));

  a_r3_reg_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_eff == LAT_REG && |lane_drive) |-> $past(port_read, 2));

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    a_r5_lane_select: assert property (@(posedge clk) disable iff (!rst_n)
      lane_drive[g] |-> $past(!byte_sel_n[g]));
  end

  a_r6_oe_floats: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (lane_drive == '0));

  a_r8_reg_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (live_cnt == 2'd3 && mode_eff == LAT_REG && $past(mode_eff) == LAT_REG
     && !$stable(dout)) |-> $past(port_read, 2));

  a_r9_mode_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (live_cnt == 2'd3 && !$stable(mode_eff))
      |-> ($past(!sel_live(ce_lo_n, ce_hi), 2) && $past(!sel_live(ce_lo_n, ce_hi), 3)));

endmodule

// File: tb/rd_latency_stage_bench.sv
module rd_latency_stage_bench;

  localparam int LANES  = 2;
  localparam int LANE_W = 9;
  localparam int W      = LANES * LANE_W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pipe_mode = 1'b0;
  logic         ce_lo_n = 1'b1;
  logic         ce_hi = 1'b0;
  logic         rw_n = 1'b1;
  logic [1:0]   byte_sel_n = 2'b11;
  logic         oe_n = 1'b0;
  logic [7:0]   addr = 8'h00;
  logic [7:0]   addr_q;
  logic [W-1:0] arr_rdata;
  logic [W-1:0] dout;
  logic [1:0]   lane_drive;

  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  // Array model: word is a fixed pattern of the address registered at the last edge.
  function automatic logic [W-1:0] pat(input logic [7:0] a);
    return {1'b1, a, ~a, 1'b0};
  endfunction

  always_ff @(posedge clk) addr_q <= addr;
  assign arr_rdata = pat(addr_q);

  rd_latency_stage #(.LANES(LANES), .LANE_W(LANE_W)) u_rd_latency_stage (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .ce_lo_n(ce_lo_n),
    .ce_hi(ce_hi), .rw_n(rw_n), .byte_sel_n(byte_sel_n), .oe_n(oe_n),
    .arr_rdata(arr_rdata), .dout(dout), .lane_drive(lane_drive)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one cycle's inputs at the falling edge, then return at the next falling edge.
  task automatic step(input logic sel, input logic rd, input logic [1:0] bsn, input logic [7:0] a);
    ce_lo_n    = !sel;
    ce_hi      = sel;
    rw_n       = rd;
    byte_sel_n = bsn;
    addr       = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 flags in reset", 32'(lane_drive), 32'h0);
    rst_n = 1'b1;
    step(1'b0, 1'b1, 2'b00, 8'h00);
    chk("R1 flags after reset", 32'(lane_drive), 32'h0);
  endtask

  task automatic t_direct_read;
    step(1'b1, 1'b1, 2'b00, 8'h11);
    chk("R2 flags", 32'(lane_drive), 32'h3);
    chk("R2 data", 32'(dout), 32'(pat(8'h11)));
    step(1'b1, 1'b1, 2'b00, 8'h22);
    chk("R2 data next", 32'(dout), 32'(pat(8'h22)));
  endtask

  task automatic t_direct_bytes;
    step(1'b1, 1'b1, 2'b10, 8'h33);
    chk("R5 lower only", 32'(lane_drive), 32'h1);
    step(1'b1, 1'b1, 2'b01, 8'h33);
    chk("R5 upper only", 32'(lane_drive), 32'h2);
    step(1'b1, 1'b1, 2'b11, 8'h33);
    chk("R5 none", 32'(lane_drive), 32'h0);
  endtask

  task automatic t_oe;
    step(1'b1, 1'b1, 2'b00, 8'h34);
    oe_n = 1'b1;
    #1;
    chk("R6 oe float", 32'(lane_drive), 32'h0);
    oe_n = 1'b0;
    #1;
    chk("R6 oe restore", 32'(lane_drive), 32'h3);
  endtask

  task automatic t_direct_write_ce;
    step(1'b1, 1'b0, 2'b00, 8'h35);
    chk("R7 direct write", 32'(lane_drive), 32'h0);
    step(1'b1, 1'b1, 2'b00, 8'h36);
    chk("R7 direct read back", 32'(lane_drive), 32'h3);
    step(1'b0, 1'b1, 2'b00, 8'h37);
    chk("R4 direct deselect one edge", 32'(lane_drive), 32'h0);
  endtask

  task automatic t_mode_switch;
    pipe_mode = 1'b1;
    step(1'b1, 1'b1, 2'b00, 8'h44);
    step(1'b1, 1'b1, 2'b00, 8'h55);
    chk("R9 latency kept while selected", 32'(dout), 32'(pat(8'h55)));
    chk("R9 flags direct", 32'(lane_drive), 32'h3);
    step(1'b0, 1'b1, 2'b00, 8'h00);
    step(1'b0, 1'b1, 2'b00, 8'h00);
    step(1'b0, 1'b1, 2'b00, 8'h00);
    step(1'b1, 1'b1, 2'b00, 8'h66);
    chk("R4 reg select needs two edges", 32'(lane_drive), 32'h0);
    step(1'b1, 1'b1, 2'b00, 8'h77);
    chk("R9 registered latency adopted", 32'(dout), 32'(pat(8'h66)));
    chk("R3 flags", 32'(lane_drive), 32'h3);
  endtask

  task automatic t_reg_read;
    step(1'b1, 1'b1, 2'b00, 8'h88);
    chk("R3 data one late", 32'(dout), 32'(pat(8'h77)));
    step(1'b1, 1'b1, 2'b00, 8'h99);
    chk("R3 data next", 32'(dout), 32'(pat(8'h88)));
  endtask

  task automatic t_reg_ce_hold;
    step(1'b0, 1'b1, 2'b00, 8'hA0);
    chk("R4 reg deselect still driving", 32'(lane_drive), 32'h3);
    chk("R3 last word", 32'(dout), 32'(pat(8'h99)));
    step(1'b0, 1'b1, 2'b00, 8'hA1);
    chk("R4 reg deselect after two", 32'(lane_drive), 32'h0);
    chk("R8 hold", 32'(dout), 32'(pat(8'h99)));
    step(1'b0, 1'b1, 2'b00, 8'hA2);
    chk("R8 hold while array moves", 32'(dout), 32'(pat(8'h99)));
  endtask

  task automatic t_reg_write_bytes;
    step(1'b1, 1'b1, 2'b00, 8'hB0);
    chk("R4 reg reselect one edge", 32'(lane_drive), 32'h0);
    step(1'b1, 1'b0, 2'b00, 8'hB1);
    chk("R3 read before write", 32'(dout), 32'(pat(8'hB0)));
    chk("R7 reg flags before turn", 32'(lane_drive), 32'h3);
    step(1'b1, 1'b1, 2'b00, 8'hB2);
    chk("R7 reg write turnaround", 32'(lane_drive), 32'h0);
    chk("R8 hold over write", 32'(dout), 32'(pat(8'hB0)));
    step(1'b1, 1'b1, 2'b00, 8'hB3);
    chk("R3 read after write", 32'(dout), 32'(pat(8'hB2)));
    step(1'b1, 1'b1, 2'b10, 8'hB4);
    chk("R5 reg byte single stage", 32'(lane_drive), 32'h1);
    oe_n = 1'b1;
    #1;
    chk("R6 reg oe float", 32'(lane_drive), 32'h0);
    oe_n = 1'b0;
  endtask

  initial begin
    #2_000_000;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    t_reset();
    t_direct_read();
    t_direct_bytes();
    t_oe();
    t_direct_write_ce();
    t_mode_switch();
    t_reg_read();
    t_reg_ce_hold();
    t_reg_write_bytes();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule